// File: doc/BRIEF.md
# Configuration Port Transfer Controller

This block sits on a simple processor register bus and moves a programmed number of bytes between a dual-port byte buffer and an 8-bit internal configuration port. The processor owns one port of the buffer and the controller owns the other. Software fills or inspects the buffer through its own port, then programs a start offset, a transfer direction and finally a byte count. Writing the count launches the transfer.

In the configure direction the controller fetches bytes from the buffer and hands them to the configuration port one at a time. In the read direction it collects bytes from the port and stores them into the buffer. The port may stall any transfer with its busy line. A done flag and an active flag in a status register tell software when the buffer may be touched again. Because a read and a configure transfer can cover the same buffer window, a read, edit and write-back cycle on configuration data needs no outside storage.

All logic runs on one clock with a synchronous active-high reset. The configuration port is clocked by the same clock.

Top module: `cfgx_ctrl`

## Requirements
- R1: After reset every register reads zero: offset, size, control and status (done 0, active 0), and `cfg_en` is low.
- R2: Register map, selected by `bus_addr[3:2]`. Offset is at 0x0 in bits [AW-1:0]. Size is at 0x4 in bits [AW:0]. Control is at 0x8, where bit 0 set means read from the port. Status is at 0xC, where bit 0 is done and bit 1 is active. A read returns its value on `bus_rdata` on the cycle after `bus_rd_en`.
- R3: In the configure direction (control bit 0 clear), the bytes at buffer addresses (offset+i) mod DEPTH, for i = 0 to size-1, are presented in order on `cfg_dout`, with `cfg_en` and `cfg_wr` high.
- R4: In the read direction, the k-th byte accepted from `cfg_din` is stored at buffer address (offset+k) mod DEPTH. All other buffer locations are left unchanged.
- R5: A byte moves only on a rising edge where `cfg_en` is high and `cfg_busy` is low. While busy is high, the address, the count and the byte held on `cfg_dout` stay put. Exactly size bytes move under any busy pattern.
- R6: Writing a nonzero size while idle starts a transfer: done reads 0 and active reads 1. When the last byte moves, done reads 1 and active reads 0.
- R7: Writing a size of zero while idle sets done without asserting `cfg_en`.
- R8: `cfg_wr` changes only when `cfg_en` is low in the same cycle and was low in the cycle before.
- R9: Register writes made while active is set are ignored, and offset, size and control read back their earlier values.
- R10: A read transfer into a window, processor edits to that window through the buffer port, and a configure transfer of the same window together send the edited bytes to the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the configuration port |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data, valid one cycle after the read strobe |
| mem_en | input | 1 | Processor buffer port enable |
| mem_we | input | 1 | Processor buffer port write |
| mem_addr | input | AW | Processor buffer port address |
| mem_wdata | input | 8 | Processor buffer port write data |
| mem_rdata | output | 8 | Processor buffer port read data, one cycle latency |
| cfg_en | output | 1 | Configuration port enable, active high |
| cfg_wr | output | 1 | Configuration port direction: 1 writes to the port, 0 reads from it |
| cfg_dout | output | 8 | Byte driven to the configuration port |
| cfg_din | input | 8 | Byte returned by the configuration port |
| cfg_busy | input | 1 | Configuration port stall |

## Verification
The hardest case to reach is a register write that lands in the middle of an active transfer. Normal transfers end within a few cycles, so such a write would usually miss the window. The bench holds the port's busy line high throughout, which freezes a configure transfer after it has started. It then rewrites every register and reads them back, and checks that the port still drives the write select, before it releases busy and confirms that the original window was sent. Busy is also driven periodically and pseudo-randomly across a sweep of offsets, sizes (including a full wrapping buffer) and both directions. This shows that stalls never drop, duplicate or reorder a byte.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TURN,
    SQ_FETCH,
    SQ_LOAD,
    SQ_WAIT,
    SQ_READ
  } seq_state_e;

  localparam logic [1:0] RSEL_OFFSET = 2'd0;
  localparam logic [1:0] RSEL_SIZE   = 2'd1;
  localparam logic [1:0] RSEL_CTRL   = 2'd2;
  localparam logic [1:0] RSEL_STAT   = 2'd3;
endpackage

// File: rtl/cfgx_dpbuf.sv
module cfgx_dpbuf #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port A serves the processor; port B serves the sequencer. Both ports read synchronously.
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_we) mem[b_addr] <= b_wdata;
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/cfgx_regs.sv
module cfgx_regs
  import cfgx_pkg::*;
#(
  parameter int AW    = 6,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             xfer_active,
  input  logic             xfer_finish,
  output logic             start,
  output logic [AW-1:0]    start_off,
  output logic [AW:0]      start_size,
  output logic             start_dir
);
  localparam int SW = AW + 1;

  logic [AW-1:0] off_q;
  logic [SW-1:0] size_q;
  logic          dir_q;
  logic          done_q;
  logic [1:0]    sel;
  logic          wr_ok;
  logic          size_wr;

  assign sel        = bus_addr[3:2];
  assign wr_ok      = bus_wr_en && !xfer_active;
  assign size_wr    = wr_ok && (sel == RSEL_SIZE);
  assign start      = size_wr && (bus_wdata[SW-1:0] != '0);
  assign start_off  = off_q;
  assign start_size = bus_wdata[SW-1:0];
  assign start_dir  = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      size_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (sel)
          RSEL_OFFSET: off_q  <= bus_wdata[AW-1:0];
          RSEL_SIZE:   size_q <= bus_wdata[SW-1:0];
          RSEL_CTRL:   dir_q  <= bus_wdata[0];
          default:     ;
        endcase
      end
      if (start) done_q <= 1'b0;
      else if (size_wr || xfer_finish) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      case (sel)
        RSEL_OFFSET: bus_rdata <= {{(BUS_W-AW){1'b0}}, off_q};
        RSEL_SIZE:   bus_rdata <= {{(BUS_W-SW){1'b0}}, size_q};
        RSEL_CTRL:   bus_rdata <= {{(BUS_W-1){1'b0}}, dir_q};
        default:     bus_rdata <= {{(BUS_W-2){1'b0}}, xfer_active, done_q};
      endcase
    end
  end

  // R9: nothing the sequencer latched can move while it is running
  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (rst)
    xfer_active |=> $stable(off_q) && $stable(size_q) && $stable(dir_q));
  // R6: a launch clears done
  a_r6_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    start |=> !done_q);
  // R6: the sequencer going idle leaves done set
  a_r6_idle_means_done: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_active) |-> done_q);
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_off,
  input  logic [AW:0]   start_size,
  input  logic          start_dir,
  output logic          active,
  output logic          finish,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic          cfg_en,
  output logic          cfg_wr,
  output logic [7:0]    cfg_dout,
  input  logic [7:0]    cfg_din,
  input  logic          cfg_busy
);
  localparam int SW = AW + 1;
  localparam logic [SW-1:0] LAST = SW'(1);

  seq_state_e    state;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] cnt_q;
  logic          dir_q;
  logic          en_q;
  logic          wr_q;
  logic [7:0]    dout_q;
  logic          moved;

  assign moved     = en_q && !cfg_busy;
  assign active    = (state != SQ_IDLE);
  assign finish    = moved && (cnt_q == LAST) && (state == SQ_WAIT || state == SQ_READ);
  assign buf_we    = (state == SQ_READ) && moved;
  assign buf_addr  = addr_q;
  assign buf_wdata = cfg_din;
  assign cfg_en    = en_q;
  assign cfg_wr    = wr_q;
  assign cfg_dout  = dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
      wr_q   <= 1'b1;
      dout_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          addr_q <= start_off;
          cnt_q  <= start_size;
          dir_q  <= start_dir;
          wr_q   <= !start_dir;   // select moves only while enable is low
          state  <= SQ_TURN;
        end
        SQ_TURN: begin
          if (dir_q) begin
            en_q  <= 1'b1;
            state <= SQ_READ;
          end else begin
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: state <= SQ_LOAD;
        SQ_LOAD: begin
          dout_q <= buf_rdata;
          en_q   <= 1'b1;
          state  <= SQ_WAIT;
        end
        SQ_WAIT: if (moved) begin
          en_q   <= 1'b0;
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          state  <= (cnt_q == LAST) ? SQ_IDLE : SQ_FETCH;
        end
        SQ_READ: if (moved) begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == LAST) begin
            en_q  <= 1'b0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8: the direction select never moves around an enabled cycle
  a_r8_select_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_q) |-> !en_q && !$past(en_q));
  // R5: a stalled byte, its address and the enable hold
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    en_q && cfg_busy |=> en_q && $stable(dout_q) && $stable(addr_q) && $stable(cnt_q));
  // R3: a running transfer always has bytes left
  a_r3_count_live: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE) |-> (cnt_q != '0));
  // R6: the final byte returns the engine to idle with the port released
  a_r6_finish_idle: assert property (@(posedge clk) disable iff (rst)
    finish |=> (state == SQ_IDLE) && !en_q);
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl #(
  parameter int AW    = 6,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             mem_en,
  input  logic             mem_we,
  input  logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_wdata,
  output logic [7:0]       mem_rdata,
  output logic             cfg_en,
  output logic             cfg_wr,
  output logic [7:0]       cfg_dout,
  input  logic [7:0]       cfg_din,
  input  logic             cfg_busy
);
  logic          active;
  logic          finish;
  logic          start;
  logic [AW-1:0] start_off;
  logic [AW:0]   start_size;
  logic          start_dir;
  logic          b_we;
  logic [AW-1:0] b_addr;
  logic [7:0]    b_wdata;
  logic [7:0]    b_rdata;

  cfgx_regs #(.AW(AW), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_active(active), .xfer_finish(finish),
    .start(start), .start_off(start_off), .start_size(start_size), .start_dir(start_dir)
  );

  cfgx_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst(rst),
    .start(start), .start_off(start_off), .start_size(start_size), .start_dir(start_dir),
    .active(active), .finish(finish),
    .buf_we(b_we), .buf_addr(b_addr), .buf_wdata(b_wdata), .buf_rdata(b_rdata),
    .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_dout(cfg_dout),
    .cfg_din(cfg_din), .cfg_busy(cfg_busy)
  );

  cfgx_dpbuf #(.AW(AW), .DW(8)) buf_i (
    .clk(clk),
    .a_en(mem_en), .a_we(mem_we), .a_addr(mem_addr), .a_wdata(mem_wdata), .a_rdata(mem_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );
endmodule

// File: tb/cfgx_ctrl_tb_top.sv
module cfgx_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr_en = 0, bus_rd_en = 0, mem_en = 0, mem_we = 0, cfg_busy = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [AW-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0, mem_rdata, cfg_dout, cfg_din;
  logic cfg_en, cfg_wr;

  int n_chk = 0, n_bad = 0;
  int cap_n = 0, src_n = 0, en_rises = 0, viol = 0, cyc = 0, busy_mode = 0;
  logic [7:0] cap [0:1023];
  logic [7:0] mdl [0:DEPTH-1];
  logic [7:0] salt = 8'h00;
  logic prev_en = 0, prev_wr = 1;
  logic [7:0] lfsr = 8'h5b;
  bit summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_ctrl #(.AW(AW), .BUS_W(32)) dut_i (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_dout(cfg_dout),
    .cfg_din(cfg_din), .cfg_busy(cfg_busy)
  );

  // Port model: source bytes follow an arithmetic sequence, sink bytes are logged.
  assign cfg_din = 8'(src_n * 37) + salt;

  always @(posedge clk) begin
    if (!rst) begin
      if (cfg_en && cfg_wr && !cfg_busy) begin
        cap[cap_n % 1024] <= cfg_dout;
        cap_n <= cap_n + 1;
      end
      if (cfg_en && !cfg_wr && !cfg_busy) src_n <= src_n + 1;
      if (cfg_en && !prev_en) en_rises <= en_rises + 1;
      if ((cfg_wr != prev_wr) && (cfg_en || prev_en)) viol <= viol + 1;
    end
    prev_en <= cfg_en;
    prev_wr <= cfg_wr;
  end

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (busy_mode)
      0: cfg_busy <= 1'b0;
      1: cfg_busy <= (cyc % 3 == 1);
      2: cfg_busy <= lfsr[0] & lfsr[2];
      default: cfg_busy <= 1'b1;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input int d);
    @(negedge clk);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_rd_en = 1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 0;
    d = int'(bus_rdata);
  endtask

  task automatic mem_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    mem_en = 1; mem_we = 1; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_en = 0; mem_we = 0;
  endtask

  task automatic mem_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    mem_en = 1; mem_we = 0; mem_addr = AW'(a);
    @(negedge clk);
    mem_en = 0;
    d = mem_rdata;
  endtask

  task automatic wait_done(input string req);
    int st = 0;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(4'hC, st);
      if (st[0]) break;
    end
    chk(st == 1, req, st, 1);
  endtask

  task automatic preload(input logic [7:0] s);
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = 8'(i * 11) ^ s;
      mem_wr(i, mdl[i]);
    end
  endtask

  task automatic run_xfer(input int off, input int sz, input bit dir);
    int st, base_c, base_s, bad;
    logic [7:0] d;
    base_c = cap_n; base_s = src_n;
    bus_wr(4'h0, off);
    bus_wr(4'h8, int'(dir));
    bus_wr(4'h4, sz);
    bus_rd(4'hC, st);
    chk(st == 2, "R6 launch status", st, 2);
    wait_done("R6 done after last byte");
    if (!dir) begin
      chk(cap_n - base_c == sz, "R5 configure byte count", cap_n - base_c, sz);
      bad = 0;
      for (int i = 0; i < sz; i++)
        if (cap[(base_c + i) % 1024] !== mdl[(off + i) % DEPTH]) bad++;
      chk(bad == 0, "R3 configure byte order", bad, 0);
    end else begin
      chk(src_n - base_s == sz, "R5 read byte count", src_n - base_s, sz);
      for (int k = 0; k < sz; k++) mdl[(off + k) % DEPTH] = 8'((base_s + k) * 37) + salt;
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_rd(i, d);
        if (d !== mdl[i]) bad++;
      end
      chk(bad == 0, "R4 read buffer image", bad, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int v, e0;
    int offs [3] = '{0, 5, 13};
    int sizes [3] = '{1, 3, 16};
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(cfg_en == 0, "R1 enable low", int'(cfg_en), 0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(4'(a * 4), v);
      chk(v == 0, "R1 register zero", v, 0);
    end
    // R7 zero size: done with no port activity
    e0 = en_rises;
    bus_wr(4'h4, 0);
    bus_rd(4'hC, v);
    chk(v == 1, "R7 zero size done", v, 1);
    chk(en_rises == e0, "R7 no port enable", en_rises - e0, 0);
    // R2 register map readback
    bus_wr(4'h0, 32'hFFFF_FFF7);
    bus_rd(4'h0, v);
    chk(v == 7, "R2 offset field width", v, 7);
    bus_wr(4'h8, 3);
    bus_rd(4'h8, v);
    chk(v == 1, "R2 control bit 0 only", v, 1);
    // Sweep: busy patterns, offsets, sizes, both directions
    for (int m = 0; m < 3; m++)
      for (int oi = 0; oi < 3; oi++)
        for (int si = 0; si < 3; si++)
          for (int dr = 0; dr < 2; dr++) begin
            busy_mode = m;
            salt = 8'(m * 50 + oi * 7 + si * 3 + dr);
            preload(salt);
            run_xfer(offs[oi], sizes[si], dr[0]);
          end
    // R9 writes during an active transfer are ignored
    busy_mode = 3;
    salt = 8'h3c;
    preload(salt);
    bus_wr(4'h0, 2);
    bus_wr(4'h8, 0);
    e0 = cap_n;
    bus_wr(4'h4, 4);
    bus_wr(4'h0, 9);
    bus_wr(4'h8, 1);
    bus_wr(4'h4, 7);
    bus_rd(4'h0, v); chk(v == 2, "R9 offset kept", v, 2);
    bus_rd(4'h8, v); chk(v == 0, "R9 control kept", v, 0);
    bus_rd(4'h4, v); chk(v == 4, "R9 size kept", v, 4);
    bus_rd(4'hC, v); chk(v == 2, "R9 status active", v, 2);
    chk(cfg_wr == 1, "R9 port still configuring", int'(cfg_wr), 1);
    busy_mode = 0;
    wait_done("R9 done");
    chk(cap_n - e0 == 4, "R9 original size sent", cap_n - e0, 4);
    v = 0;
    for (int i = 0; i < 4; i++) if (cap[(e0 + i) % 1024] !== mdl[(2 + i) % DEPTH]) v++;
    chk(v == 0, "R9 original window sent", v, 0);
    // R10 readback, edit, write back
    busy_mode = 2;
    salt = 8'h91;
    preload(8'h10);
    run_xfer(4, 6, 1'b1);
    for (int i = 4; i < 10; i++) begin
      mem_rd(i, d);
      mdl[i] = d ^ 8'hA5;
      mem_wr(i, mdl[i]);
    end
    e0 = cap_n;
    run_xfer(4, 6, 1'b0);
    v = 0;
    for (int i = 0; i < 6; i++) if (cap[(e0 + i) % 1024] !== ((8'((src_n - 6 + i) * 37) + salt) ^ 8'hA5)) v++;
    chk(v == 0, "R10 edited bytes sent", v, 0);
    // R8 direction select discipline over the whole run
    chk(viol == 0, "R8 select change while enabled", viol, 0);
    summary_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule